// File: doc/BRIEF.md
# Cache Portion Allocation Bitmap Store

This block keeps, for every partition ID, a bitmap that says which portions of a shared cache that partition may allocate into. The state is held twice, once for a secure bank and once for a non-secure bank. Each bank has its own partition selector register. Software writes the selector first, then reads or writes the chosen partition's bitmap through a window of 32-bit words in the same bank's register page.

The cache side asks through a combinational lookup port. It presents a partition ID, a security bit and a portion index, and gets back a single allow or deny bit. The bitmap width, the number of partition IDs and whether portion partitioning exists at all are parameters. Bits beyond the configured width take no storage.

Register accesses use a plain single-cycle request interface: an enable, a write strobe, a bank bit, a byte offset and write data. Read data comes back one cycle after the request.

Top module: `portion_mask_store`

## Requirements
- R1: With `lk_secure`, `lk_part` and `lk_index` in range, `lk_allow` combinationally equals the stored bit `lk_index` of that partition's bitmap in the chosen bank. 1 allows allocation and 0 denies it.
- R2: After reset, every implemented bitmap bit of every partition in both banks is 1, and both selectors read as 0.
- R3: Each bank has a 16-bit partition selector at byte offset 0x0100. It reads back as `{16'h0, value}`, and it decides which partition the bitmap window reaches.
- R4: Word k of the bitmap window sits at byte offset 0x1000 + 4*k and holds bitmap bits 32k to 32k+31, with bit 32k in data bit 0. Read data appears on `reg_rdata` with `reg_rvalid` high in the cycle after the read request.
- R5: `reg_bank` = 1 selects the secure bank and 0 selects the non-secure bank. An access in one bank never changes the other bank's selector or bitmaps.
- R6: Bitmap bits at or above `BM_WIDTH` read as 0, and writes to them are ignored.
- R7: Window words at or beyond ceil(`BM_WIDTH`/32) read as 0, and writes to them change nothing.
- R8: While a bank's selector is at or above `NUM_PART`, window reads in that bank return 0 and window writes are dropped.
- R9: With `FEATURE_EN` = 0, window reads return 0 and window writes are ignored. The lookup then allows every in-range portion and partition.
- R10: `lk_allow` is 0 whenever `lk_index` >= `BM_WIDTH` or `lk_part` >= `NUM_PART`.
- R11: Reads at any offset other than the selector and aligned window words return 0. Writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_bank | input | 1 | 1 = secure bank, 0 = non-secure bank |
| reg_addr | input | 16 | Byte offset within the bank page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| lk_secure | input | 1 | Bank used for the lookup |
| lk_part | input | 16 | Partition ID used for the lookup |
| lk_index | input | 15 | Cache portion index used for the lookup |
| lk_allow | output | 1 | 1 = allocation into the portion is allowed |

## Verification
The assertions assume that `reg_en` is never high during reset, and that the lookup inputs are driven to known values on every clock edge. The bench drives every register request for exactly one cycle, from the falling edge, and keeps the lookup inputs at defined values from time zero onward. A second instance with the feature disabled shares the data and address inputs but has its own enable, so its requests never overlap those of the main instance.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned SEL_BITS  = 16;
    localparam int unsigned IDX_BITS  = 15;
    localparam int unsigned MAX_WORDS = 1024;

    localparam logic [15:0] SEL_OFFSET = 16'h0100;
    localparam logic [3:0]  WIN_PAGE   = 4'h1;

    // Kind of register access produced by the decoder
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_WIN  = 2'd2
    } acc_kind_e;

    // Decoded access carried to the read mux and the write strobes
    typedef struct packed {
        acc_kind_e kind;
        logic      word_ok;
    } acc_dec_t;

    function automatic int unsigned words_for(int unsigned width);
        return (width + WORD_BITS - 1) / WORD_BITS;
    endfunction

    // Mask of the bits of word k that fall below the configured width
    function automatic logic [31:0] word_mask(int unsigned width, int unsigned k);
        logic [31:0] m;
        for (int unsigned i = 0; i < WORD_BITS; i++) begin
            m[i] = ((k * WORD_BITS + i) < width);
        end
        return m;
    endfunction

endpackage

// File: rtl/pmask_decode.sv
module pmask_decode
    import pmask_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 4,
    localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [15:0]       addr,
    output acc_dec_t          dec,
    output logic [WORD_W-1:0] word_idx
);

    always_comb begin
        dec.kind    = ACC_NONE;
        dec.word_ok = 1'b0;
        word_idx    = addr[2 +: WORD_W];
        if (addr == SEL_OFFSET) begin
            dec.kind = ACC_SEL;
        end else if (addr[15:12] == WIN_PAGE && addr[1:0] == 2'b00) begin
            dec.kind    = ACC_WIN;
            dec.word_ok = (32'(addr[11:2]) < NUM_WORDS);
        end
    end

endmodule

// File: rtl/pmask_bank.sv
module pmask_bank
    import pmask_pkg::*;
#(
    parameter int unsigned BM_WIDTH   = 100,
    parameter int unsigned NUM_PART   = 6,
    parameter bit          FEATURE_EN = 1'b1,
    localparam int unsigned NUM_WORDS = words_for(BM_WIDTH),
    localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned PART_W    = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_sel,
    input  logic                wr_win,
    input  logic [WORD_W-1:0]   word,
    input  logic [31:0]         wdata,
    output logic [SEL_BITS-1:0] sel,
    output logic [31:0]         rd_word,
    input  logic [SEL_BITS-1:0] lk_part,
    input  logic [IDX_BITS-1:0] lk_index,
    output logic                lk_allow
);

    logic sel_ok;
    logic lk_in_range;

    assign sel_ok      = (32'(sel) < NUM_PART);
    assign lk_in_range = (32'(lk_part) < NUM_PART) && (32'(lk_index) < BM_WIDTH);

    // Per-bank partition selector
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (wr_sel) begin
            sel <= wdata[SEL_BITS-1:0];
        end
    end

    generate
        if (FEATURE_EN) begin : g_store
            logic [31:0] mem [NUM_PART][NUM_WORDS];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int p = 0; p < NUM_PART; p++) begin
                        for (int w = 0; w < NUM_WORDS; w++) begin
                            mem[p][w] <= word_mask(BM_WIDTH, w);
                        end
                    end
                end else if (wr_win && sel_ok) begin
                    mem[sel[PART_W-1:0]][word] <= wdata & word_mask(BM_WIDTH, 32'(word));
                end
            end

            assign rd_word  = sel_ok ? mem[sel[PART_W-1:0]][word] : '0;
            assign lk_allow = lk_in_range &&
                              mem[lk_part[PART_W-1:0]][lk_index[5 +: WORD_W]][lk_index[4:0]];
        end else begin : g_absent
            assign rd_word  = '0;
            assign lk_allow = lk_in_range;
        end
    endgenerate

endmodule

// File: rtl/portion_mask_store.sv
module portion_mask_store
    import pmask_pkg::*;
#(
    parameter int unsigned BM_WIDTH   = 100,
    parameter int unsigned NUM_PART   = 6,
    parameter bit          FEATURE_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic        reg_bank,
    input  logic [15:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    input  logic        lk_secure,
    input  logic [15:0] lk_part,
    input  logic [14:0] lk_index,
    output logic        lk_allow
);

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned NUM_WORDS = words_for(BM_WIDTH);
    localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    initial begin
        if (BM_WIDTH < 1 || BM_WIDTH > MAX_WORDS * WORD_BITS) begin
            $error("portion_mask_store: BM_WIDTH out of range");
        end
        if (NUM_PART < 1 || NUM_PART > (1 << SEL_BITS)) begin
            $error("portion_mask_store: NUM_PART out of range");
        end
    end

    acc_dec_t          dec;
    logic [WORD_W-1:0] word_idx;

    logic [SEL_BITS-1:0] sel_val  [NUM_BANKS];
    logic [31:0]         win_word [NUM_BANKS];
    logic [NUM_BANKS-1:0] allow_b;
    logic [31:0]         rd_next;

    pmask_decode #(
        .NUM_WORDS(NUM_WORDS)
    ) u_decode (
        .addr     (reg_addr),
        .dec      (dec),
        .word_idx (word_idx)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = reg_en && reg_we && (reg_bank == 1'(b));

            pmask_bank #(
                .BM_WIDTH   (BM_WIDTH),
                .NUM_PART   (NUM_PART),
                .FEATURE_EN (FEATURE_EN)
            ) u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_sel   (hit && dec.kind == ACC_SEL),
                .wr_win   (hit && dec.kind == ACC_WIN && dec.word_ok),
                .word     (word_idx),
                .wdata    (reg_wdata),
                .sel      (sel_val[b]),
                .rd_word  (win_word[b]),
                .lk_part  (lk_part),
                .lk_index (lk_index),
                .lk_allow (allow_b[b])
            );
        end
    endgenerate

    assign lk_allow = allow_b[lk_secure];

    always_comb begin
        rd_next = '0;
        unique case (dec.kind)
            ACC_SEL: rd_next = {16'h0, sel_val[reg_bank]};
            ACC_WIN: rd_next = dec.word_ok ? win_word[reg_bank] : '0;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_en && !reg_we;
            reg_rdata  <= (reg_en && !reg_we) ? rd_next : '0;
        end
    end

endmodule

// File: rtl/pmask_checker.sv
module pmask_checker
    import pmask_pkg::*;
#(
    parameter int unsigned BM_WIDTH   = 100,
    parameter int unsigned NUM_PART   = 6,
    parameter bit          FEATURE_EN = 1'b1,
    localparam int unsigned NUM_WORDS = words_for(BM_WIDTH),
    localparam logic [31:0] LAST_MASK = word_mask(BM_WIDTH, NUM_WORDS - 1)
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_en,
    input logic        reg_we,
    input logic        reg_bank,
    input logic [15:0] reg_addr,
    input logic [31:0] reg_rdata,
    input logic        reg_rvalid,
    input logic [15:0] lk_part,
    input logic [14:0] lk_index,
    input logic        lk_allow,
    input logic [15:0] sel_ns,
    input logic [15:0] sel_s
);

    logic rd_req;
    logic win_acc;
    logic [15:0] cur_sel;

    assign rd_req  = reg_en && !reg_we;
    assign win_acc = (reg_addr[15:12] == 4'h1) && (reg_addr[1:0] == 2'b00);
    assign cur_sel = reg_bank ? sel_s : sel_ns;

    // R4: a read request is answered in the next cycle
    assert_read_answered_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> reg_rvalid);

    // R10: out-of-range portion index is denied
    assert_index_denied_R10: assert property (@(posedge clk) disable iff (rst)
        (32'(lk_index) >= BM_WIDTH) |-> !lk_allow);

    // R10: out-of-range partition ID is denied
    assert_part_denied_R10: assert property (@(posedge clk) disable iff (rst)
        (32'(lk_part) >= NUM_PART) |-> !lk_allow);

    // R8: window read with an out-of-range selector returns zero
    assert_bad_sel_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && win_acc && 32'(cur_sel) >= NUM_PART) |=> (reg_rdata == 32'h0));

    // R5: a write in one bank leaves the other bank's selector unchanged
    assert_ns_write_keeps_s_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && !reg_bank) |=> $stable(sel_s));

    assert_s_write_keeps_ns_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_en && reg_we && reg_bank) |=> $stable(sel_ns));

    // R6: unimplemented bits of the last word read as zero
    assert_last_word_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && win_acc && 32'(reg_addr[11:2]) == NUM_WORDS - 1)
            |=> ((reg_rdata & ~LAST_MASK) == 32'h0));

    // R11: reads outside the selector and window return zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !win_acc && reg_addr != 16'h0100) |=> (reg_rdata == 32'h0));

    generate
        if (!FEATURE_EN) begin : g_absent_chk
            // R9: window reads return zero when the feature is absent
            assert_absent_zero_R9: assert property (@(posedge clk) disable iff (rst)
                (rd_req && win_acc) |=> (reg_rdata == 32'h0));
        end
    endgenerate

endmodule

bind portion_mask_store pmask_checker #(
    .BM_WIDTH   (BM_WIDTH),
    .NUM_PART   (NUM_PART),
    .FEATURE_EN (FEATURE_EN)
) u_pmask_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_bank   (reg_bank),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .lk_part    (lk_part),
    .lk_index   (lk_index),
    .lk_allow   (lk_allow),
    .sel_ns     (sel_val[0]),
    .sel_s      (sel_val[1])
);

// File: tb/test_portion_mask_store.sv
module test_portion_mask_store;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0;
    logic        nf_en = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_bank = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, nf_rdata;
    logic        reg_rvalid, nf_rvalid;
    logic        lk_secure = 1'b0;
    logic [15:0] lk_part = '0;
    logic [14:0] lk_index = '0;
    logic        lk_allow, nf_allow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    portion_mask_store #(.BM_WIDTH(100), .NUM_PART(6), .FEATURE_EN(1'b1)) i_portion_mask_store (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_bank(reg_bank),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .lk_secure(lk_secure), .lk_part(lk_part),
        .lk_index(lk_index), .lk_allow(lk_allow)
    );

    portion_mask_store #(.BM_WIDTH(100), .NUM_PART(6), .FEATURE_EN(1'b0)) i_portion_mask_store_nf (
        .clk(clk), .rst(rst), .reg_en(nf_en), .reg_we(reg_we), .reg_bank(reg_bank),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(nf_rdata),
        .reg_rvalid(nf_rvalid), .lk_secure(lk_secure), .lk_part(lk_part),
        .lk_index(lk_index), .lk_allow(nf_allow)
    );

    // Monitor: pops expected read data as the design answers
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected rvalid: actual %h expected none", reg_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic bank, input logic [15:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_bank = bank; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic bank, input logic [15:0] addr, input logic [31:0] exp,
                      input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_bank = bank; reg_addr = addr;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic chk_lk(input logic sec, input logic [15:0] part, input logic [14:0] idx,
                          input logic exp, input string tag);
        @(negedge clk);
        lk_secure = sec; lk_part = part; lk_index = idx;
        #(CLK_PERIOD / 4);
        n_checks++;
        if (lk_allow !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, lk_allow, exp);
        end
    endtask

    task automatic chk_lk_nf(input logic [15:0] part, input logic [14:0] idx,
                             input logic exp, input string tag);
        @(negedge clk);
        lk_secure = 1'b0; lk_part = part; lk_index = idx;
        #(CLK_PERIOD / 4);
        n_checks++;
        if (nf_allow !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, nf_allow, exp);
        end
    endtask

    task automatic nf_access(input logic we, input logic [15:0] addr, input logic [31:0] data,
                             input logic [31:0] exp, input string tag);
        @(negedge clk);
        nf_en = 1'b1; reg_we = we; reg_bank = 1'b0; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        nf_en = 1'b0; reg_we = 1'b0;
        if (!we) begin
            n_checks++;
            if (!nf_rvalid || nf_rdata !== exp) begin
                n_fail++;
                $display("FAIL %s: actual %h (valid %b) expected %h", tag, nf_rdata, nf_rvalid, exp);
            end
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2, R3: reset state of selectors
        rd(1'b0, 16'h0100, 32'h0, "R2 ns selector reset");
        rd(1'b1, 16'h0100, 32'h0, "R2 s selector reset");
        // R2, R4, R6: reset bitmap, last word holds only 4 bits
        rd(1'b0, 16'h1000, 32'hFFFF_FFFF, "R2 word0 reset");
        rd(1'b0, 16'h1004, 32'hFFFF_FFFF, "R4 word1 reset");
        rd(1'b1, 16'h1008, 32'hFFFF_FFFF, "R2 s word2 reset");
        rd(1'b0, 16'h100C, 32'h0000_000F, "R6 last word reset");
        chk_lk(1'b1, 16'd3, 15'd50, 1'b1, "R2 lookup after reset");

        // R1, R3, R4: partition 2 in ns bank, word 1
        wr(1'b0, 16'h0100, 32'h0000_0002);
        rd(1'b0, 16'h0100, 32'h0000_0002, "R3 selector readback");
        rd(1'b1, 16'h0100, 32'h0, "R5 other selector untouched");
        wr(1'b0, 16'h1004, 32'hA5A5_0F0F);
        rd(1'b0, 16'h1004, 32'hA5A5_0F0F, "R4 word1 readback");
        chk_lk(1'b0, 16'd2, 15'd32, 1'b1, "R1 bit32 set");
        chk_lk(1'b0, 16'd2, 15'd36, 1'b0, "R1 bit36 clear");
        chk_lk(1'b0, 16'd2, 15'd56, 1'b1, "R1 bit56 set");
        chk_lk(1'b1, 16'd2, 15'd36, 1'b1, "R5 secure bank unchanged");
        chk_lk(1'b0, 16'd1, 15'd36, 1'b1, "R1 other partition unchanged");
        wr(1'b1, 16'h0100, 32'h0000_0002);
        rd(1'b1, 16'h1004, 32'hFFFF_FFFF, "R5 secure word1 untouched");

        // R6: upper bits of last word
        wr(1'b0, 16'h100C, 32'hFFFF_FFF0);
        rd(1'b0, 16'h100C, 32'h0, "R6 last word low bits cleared");
        chk_lk(1'b0, 16'd2, 15'd99, 1'b0, "R1 bit99 clear");
        chk_lk(1'b0, 16'd2, 15'd100, 1'b0, "R10 index at width");
        wr(1'b0, 16'h100C, 32'hFFFF_FFFF);
        rd(1'b0, 16'h100C, 32'h0000_000F, "R6 unstored bits read zero");
        chk_lk(1'b0, 16'd2, 15'd99, 1'b1, "R1 bit99 set");

        // R7: words past the last implemented word
        wr(1'b0, 16'h1010, 32'h1234_5678);
        rd(1'b0, 16'h1010, 32'h0, "R7 word4 reads zero");
        rd(1'b0, 16'h1FFC, 32'h0, "R7 word1023 reads zero");
        rd(1'b0, 16'h1000, 32'hFFFF_FFFF, "R7 write did not alias word0");

        // R8: out-of-range selector
        wr(1'b0, 16'h0100, 32'h0000_0006);
        rd(1'b0, 16'h1000, 32'h0, "R8 window reads zero");
        wr(1'b0, 16'h1000, 32'h0);
        wr(1'b0, 16'h0100, 32'h0000_0005);
        rd(1'b0, 16'h1000, 32'hFFFF_FFFF, "R8 write dropped");
        chk_lk(1'b0, 16'd6, 15'd0, 1'b0, "R10 partition at limit");
        chk_lk(1'b0, 16'hFFFF, 15'd0, 1'b0, "R10 partition max");
        chk_lk(1'b0, 16'd5, 15'h7FFF, 1'b0, "R10 index max");

        // R3: full 16-bit selector, upper data bits not stored
        wr(1'b0, 16'h0100, 32'hFFFF_ABCD);
        rd(1'b0, 16'h0100, 32'h0000_ABCD, "R3 16-bit selector");
        rd(1'b0, 16'h1004, 32'h0, "R8 large selector window zero");

        // R11: unmapped offsets
        wr(1'b0, 16'h0100, 32'h0000_0000);
        wr(1'b0, 16'h1002, 32'h0);
        rd(1'b0, 16'h0200, 32'h0, "R11 offset 0x0200");
        rd(1'b0, 16'h1002, 32'h0, "R11 unaligned window");
        rd(1'b0, 16'h2000, 32'h0, "R11 offset 0x2000");
        rd(1'b0, 16'h1000, 32'hFFFF_FFFF, "R11 unaligned write ignored");

        // R5: secure bank partition 0
        wr(1'b1, 16'h0100, 32'h0000_0000);
        wr(1'b1, 16'h1000, 32'h1234_5678);
        rd(1'b1, 16'h1000, 32'h1234_5678, "R5 secure word0 readback");
        rd(1'b0, 16'h1000, 32'hFFFF_FFFF, "R5 ns word0 untouched");
        chk_lk(1'b1, 16'd0, 15'd3, 1'b1, "R1 secure bit3 set");
        chk_lk(1'b1, 16'd0, 15'd0, 1'b0, "R1 secure bit0 clear");
        chk_lk(1'b0, 16'd0, 15'd0, 1'b1, "R5 ns bit0 still set");

        // R9: feature absent instance
        nf_access(1'b0, 16'h1000, 32'h0, 32'h0, "R9 absent window read");
        nf_access(1'b1, 16'h0100, 32'h0000_0001, 32'h0, "R9 selector write");
        nf_access(1'b0, 16'h0100, 32'h0, 32'h0000_0001, "R9 selector still works");
        nf_access(1'b1, 16'h1004, 32'h0, 32'h0, "R9 absent window write");
        nf_access(1'b0, 16'h1004, 32'h0, 32'h0, "R9 absent window read after write");
        chk_lk_nf(16'd0, 15'd5, 1'b1, "R9 absent lookup allows");
        chk_lk_nf(16'd1, 15'd99, 1'b1, "R9 absent lookup allows top bit");
        chk_lk_nf(16'd0, 15'd100, 1'b0, "R10 absent index at width");
        chk_lk_nf(16'd6, 15'd5, 1'b0, "R10 absent partition at limit");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 reads not answered: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule